// File: doc/BRIEF.md
# Converter Shutdown and Wake Sequencer

This block decides the power state of a sampling converter from two pins: an active-low shutdown request and the chip select. While shutdown is requested, the chip select level chooses how deep the converter goes. With chip select low it enters a light state, where only the reference and the digital logic stay powered. With chip select high it enters a deep state, where the reference is off as well. The block drives one enable for the analog core and one for the reference. It reports its state on a two-bit status output.

When the shutdown request is released, the block powers the rails back up. It then counts a wake interval in clock cycles and only after that raises `ready_o`. There are two intervals. The short one applies when the reference is known to be settled. The long one applies whenever the reference was switched off, or has never completed a wake since reset. Conversion start requests are edge-detected. A start that arrives while the converter is ready produces a one-cycle launch pulse. A start that arrives at any other time is dropped and sets a sticky error flag.

All three pins are asynchronous and pass through synchronizers before any decision uses them. Both wake intervals are parameters, so a system can set them to its own clock: about 200 ns for the short interval and about 160 ms for the long one.

Top module: `pwr_mode_ctl`

## Requirements
- R1: Each of the three pin inputs passes through a two-flop synchronizer. A change on a pin, set up before a rising clock edge, becomes visible on the outputs right after the third rising edge and not earlier.
- R2: `mode_o` encodes the state as follows: 2'b00 active, 2'b01 light shutdown, 2'b10 deep shutdown, 2'b11 waking.
- R3: While the synchronized shutdown input is low, the synchronized select is evaluated on every cycle. Select low gives the light state and select high gives the deep state, so a select rise during the light state moves the block to the deep state. While shutdown is released, the select level has no effect on the state.
- R4: `core_pwr_en_o` is high only in the active and waking states. `ref_pwr_en_o` is low only in the deep state.
- R5: If the reference is settled when shutdown is released, the block stays in the waking state for exactly NAP_WAKE_CYC cycles. It then enters the active state with `ready_o` high. `ready_o` is high only in the active state.
- R6: The reference counts as settled only once a wake has completed into the active state. It counts as unsettled after reset and after any entry into the deep state. A release from shutdown while the reference is unsettled gives exactly SLEEP_WAKE_CYC waking cycles, including a release from the light state. While shutdown stays requested, the block does not leave the shutdown state.
- R7: If shutdown is requested again during the waking state, the count is cancelled at once and the block enters the shutdown state chosen by the select. A later release starts a new full count.
- R8: A synchronized rising edge on `conv_req_i` in the active state gives exactly one high cycle on `conv_go_o`, three clock edges after the pin rose, however long the request stays high.
- R9: A synchronized rising edge on `conv_req_i` in any state other than active gives no pulse on `conv_go_o`. It sets `conv_err_o`, which then stays high until reset.
- R10: During reset and directly after it, `mode_o` is 2'b10 (deep), both enables are low, and `ready_o`, `conv_go_o` and `conv_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n_i | input | 1 | Asynchronous shutdown request, active low |
| sel_n_i | input | 1 | Asynchronous chip select, also the shutdown depth select |
| conv_req_i | input | 1 | Asynchronous conversion start request, rising edge |
| core_pwr_en_o | output | 1 | Analog core power enable |
| ref_pwr_en_o | output | 1 | Reference power enable |
| ready_o | output | 1 | Converter ready for a conversion |
| conv_go_o | output | 1 | One-cycle accepted conversion launch |
| conv_err_o | output | 1 | Sticky flag for a start request that was refused |
| mode_o | output | 2 | Current state (encoding in R2) |

## Verification
On every cycle, the assertions check these relations:
- the core enable never appears without the reference enable;
- ready rises only out of the waking state;
- the waking state is entered only from a shutdown state and never lasts longer than the long interval;
- a shutdown request during waking ends the waking state on the next cycle;
- a launch pulse lasts one cycle and only follows a ready cycle;
- the error flag never falls.

Several behaviours can only be shown by the bench's scenarios, because they depend on history:
- the exact three-edge latency;
- the exact length of each wake interval;
- the choice of the long interval after a cancelled deep wake, even when the block passed through the light state;
- the nap-to-deep move on a select rise.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int unsigned NAP_WAKE_CYC   = 25,
  parameter int unsigned SLEEP_WAKE_CYC = 20000000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n_i,
  input  logic       sel_n_i,
  input  logic       conv_req_i,
  output logic       core_pwr_en_o,
  output logic       ref_pwr_en_o,
  output logic       ready_o,
  output logic       conv_go_o,
  output logic       conv_err_o,
  output logic [1:0] mode_o
);

  localparam int unsigned MAX_CYC = (SLEEP_WAKE_CYC > NAP_WAKE_CYC) ? SLEEP_WAKE_CYC : NAP_WAKE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] NAP_LD = CNT_W'(NAP_WAKE_CYC);
  localparam logic [CNT_W-1:0] SLP_LD = CNT_W'(SLEEP_WAKE_CYC);

  typedef enum logic [1:0] {
    M_ACT  = 2'b00,
    M_NAP  = 2'b01,
    M_SLP  = 2'b10,
    M_WAKE = 2'b11
  } mode_e;

  logic [SYNC_STAGES-1:0] sd_q, cs_q, rq_q;
  logic                   sd_s, cs_s, rq_s, rq_d, req_edge;
  mode_e                  state;
  logic [CNT_W-1:0]       cnt;
  logic                   ref_ok, go_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q <= '0;
      cs_q <= '1;
      rq_q <= '0;
    end else begin
      sd_q <= {sd_q[SYNC_STAGES-2:0], shdn_n_i};
      cs_q <= {cs_q[SYNC_STAGES-2:0], sel_n_i};
      rq_q <= {rq_q[SYNC_STAGES-2:0], conv_req_i};
    end
  end

  assign sd_s     = sd_q[SYNC_STAGES-1];
  assign cs_s     = cs_q[SYNC_STAGES-1];
  assign rq_s     = rq_q[SYNC_STAGES-1];
  assign req_edge = rq_s & ~rq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= M_SLP;
      cnt    <= '0;
      ref_ok <= 1'b0;
      rq_d   <= 1'b0;
      go_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rq_d <= rq_s;
      go_q <= req_edge && (state == M_ACT);
      if (req_edge && (state != M_ACT)) err_q <= 1'b1;

      if (!sd_s) begin
        state <= cs_s ? M_SLP : M_NAP;
        cnt   <= '0;
        if (cs_s) ref_ok <= 1'b0;
      end else begin
        case (state)
          M_NAP, M_SLP: begin
            state <= M_WAKE;
            cnt   <= ref_ok ? NAP_LD : SLP_LD;
          end
          M_WAKE: begin
            if (cnt <= 1) begin
              state  <= M_ACT;
              ref_ok <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: state <= M_ACT;
        endcase
      end
    end
  end

  assign mode_o        = state;
  assign ready_o       = (state == M_ACT);
  assign core_pwr_en_o = (state == M_ACT) || (state == M_WAKE);
  assign ref_pwr_en_o  = (state != M_SLP);
  assign conv_go_o     = go_q;
  assign conv_err_o    = err_q;

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int unsigned NAP_WAKE_CYC   = 25,
  parameter int unsigned SLEEP_WAKE_CYC = 20000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sd_s,
  input logic       core_en,
  input logic       ref_en,
  input logic       ready,
  input logic       go,
  input logic       err,
  input logic [1:0] mode
);

  localparam int unsigned MAX_CYC = (SLEEP_WAKE_CYC > NAP_WAKE_CYC) ? SLEEP_WAKE_CYC : NAP_WAKE_CYC;

  int unsigned wake_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wake_run <= 0;
    else if (mode == 2'b11) wake_run <= wake_run + 1;
    else                   wake_run <= 0;
  end

  p_core_needs_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> ref_en);

  p_ready_after_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(mode) == 2'b11);

  p_wake_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && $past(mode) != 2'b11) |-> ($past(mode) == 2'b01 || $past(mode) == 2'b10));

  p_wake_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_run <= MAX_CYC);

  p_cancel_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_s && mode == 2'b11) |=> (mode == 2'b01 || mode == 2'b10));

  p_go_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(ready));

  p_go_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(
  .NAP_WAKE_CYC(NAP_WAKE_CYC),
  .SLEEP_WAKE_CYC(SLEEP_WAKE_CYC)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .sd_s(sd_s),
  .core_en(core_pwr_en_o),
  .ref_en(ref_pwr_en_o),
  .ready(ready_o),
  .go(conv_go_o),
  .err(conv_err_o),
  .mode(mode_o)
);

// File: tb/pwr_mode_ctl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctl_tb_top;
  localparam int NAP = 6;
  localparam int SLP = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn_n = 1'b0, sel_n = 1'b1, req = 1'b0;
  logic core_en, ref_en, ready, go, err;
  logic [1:0] mode;

  int vectors = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctl #(.NAP_WAKE_CYC(NAP), .SLEEP_WAKE_CYC(SLP), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .shdn_n_i(shdn_n), .sel_n_i(sel_n), .conv_req_i(req),
    .core_pwr_en_o(core_en), .ref_pwr_en_o(ref_en), .ready_o(ready),
    .conv_go_o(go), .conv_err_o(err), .mode_o(mode)
  );

  // behavioural reference model
  int m_mode, m_rem;
  bit m_settled, m_go, m_err, m_edge;
  bit m_sd1, m_sd2, m_cs1, m_cs2, m_rq1, m_rq2, m_rq3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2; m_rem = 0; m_settled = 0; m_go = 0; m_err = 0;
      m_sd1 = 0; m_sd2 = 0; m_cs1 = 1; m_cs2 = 1; m_rq1 = 0; m_rq2 = 0; m_rq3 = 0;
    end else begin
      m_edge = m_rq2 && !m_rq3;
      m_go = m_edge && (m_mode == 0);
      if (m_edge && m_mode != 0) m_err = 1;
      if (!m_sd2) begin
        m_mode = m_cs2 ? 2 : 1;
        if (m_cs2) m_settled = 0;
      end else if (m_mode == 1 || m_mode == 2) begin
        m_rem = m_settled ? NAP : SLP;
        m_mode = 3;
      end else if (m_mode == 3) begin
        if (m_rem <= 1) begin m_mode = 0; m_settled = 1; end
        else m_rem = m_rem - 1;
      end
      m_rq3 = m_rq2; m_rq2 = m_rq1; m_rq1 = req;
      m_sd2 = m_sd1; m_sd1 = shdn_n;
      m_cs2 = m_cs1; m_cs1 = sel_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(mode == m_mode[1:0], "R2 mode", mode, m_mode);
      chk(core_en == (m_mode == 0 || m_mode == 3), "R4 core enable", core_en, (m_mode == 0 || m_mode == 3));
      chk(ref_en == (m_mode != 2), "R4 ref enable", ref_en, (m_mode != 2));
      chk(ready == (m_mode == 0), "R5 ready", ready, (m_mode == 0));
      chk(go == m_go, "R8 go", go, m_go);
      chk(err == m_err, "R9 err", err, m_err);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_wake(output int len);
    int guard = 0;
    len = 0;
    while (mode != 2'b11 && guard < 50) begin guard++; tick(1); end
    while (mode == 2'b11 && len < 500) begin len++; tick(1); end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int len, pulses;
    tick(1);
    cmp_on = 1'b1;
    tick(2);
    chk(mode == 2'b10 && !core_en && !ref_en && !ready && !go && !err, "R10 reset state", mode, 2);
    rst_n = 1'b1;
    tick(6);
    chk(mode == 2'b10, "R6 stays deep while shutdown held", mode, 2);

    shdn_n = 1'b1;
    measure_wake(len);
    chk(len == SLP, "R6 wake after reset", len, SLP);
    chk(ready == 1'b1, "R5 ready after wake", ready, 1);

    req = 1'b1;
    tick(3);
    chk(go == 1'b1, "R8 go latency", go, 1);
    pulses = 1;
    for (int i = 0; i < 8; i++) begin tick(1); if (go) pulses++; end
    chk(pulses == 1, "R8 single pulse on held request", pulses, 1);
    req = 1'b0;
    tick(4);

    sel_n = 1'b0;
    tick(4);
    chk(mode == 2'b00, "R3 select ignored while released", mode, 0);
    shdn_n = 1'b0;
    tick(2);
    chk(mode == 2'b00, "R1 no change before third edge", mode, 0);
    tick(1);
    chk(mode == 2'b01, "R1 change at third edge", mode, 1);
    chk(!core_en && ref_en, "R3 light state rails", {core_en, ref_en}, 1);

    sel_n = 1'b1;
    tick(3);
    chk(mode == 2'b10 && !ref_en, "R3 light to deep on select rise", mode, 2);
    sel_n = 1'b0;
    tick(3);
    chk(mode == 2'b01, "R3 deep to light on select fall", mode, 1);

    req = 1'b1;
    tick(4);
    chk(err == 1'b1 && go == 1'b0, "R9 refused start", err, 1);
    req = 1'b0;
    tick(3);

    shdn_n = 1'b1;
    measure_wake(len);
    chk(len == SLP, "R6 unsettled reference from light state", len, SLP);

    shdn_n = 1'b0;
    tick(4);
    shdn_n = 1'b1;
    measure_wake(len);
    chk(len == NAP, "R5 short wake from light state", len, NAP);

    shdn_n = 1'b0;
    tick(4);
    shdn_n = 1'b1;
    tick(5);
    chk(mode == 2'b11, "R7 waking before cancel", mode, 3);
    shdn_n = 1'b0; sel_n = 1'b1;
    tick(3);
    chk(mode == 2'b10, "R7 cancel into deep", mode, 2);
    sel_n = 1'b0;
    tick(3);
    shdn_n = 1'b1;
    measure_wake(len);
    chk(len == SLP, "R7 full long count after deep", len, SLP);

    shdn_n = 1'b0; sel_n = 1'b1;
    tick(4);
    shdn_n = 1'b1; sel_n = 1'b0;
    tick(13);
    chk(mode == 2'b11, "R7 waking from deep", mode, 3);
    shdn_n = 1'b0;
    tick(3);
    chk(mode == 2'b01, "R7 cancel into light", mode, 1);
    shdn_n = 1'b1;
    measure_wake(len);
    chk(len == SLP, "R7 reference still unsettled", len, SLP);

    tick(2);
    chk(err == 1'b1, "R9 error stays set", err, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule